// File: doc/BRIEF.md
# Tag-Register Indexed Miss Filter

This block sits beside one level of a cache hierarchy and answers, one cycle after a lookup, whether an access to that level is certain to miss. Such accesses can skip the level. A small set of K tag registers holds the upper address bits of groups of blocks that are currently resident. A lookup compares its upper bits against every register in parallel. When a register matches, that register's number is joined with the low M address bits. The result selects one counter in a table of K·2^M saturating counters, and each counter records how many resident blocks share its address.

A definite miss is reported when no register holds the upper bits, or when the selected counter is zero. Otherwise the answer is maybe-hit. The cache reports every block it places and every block it removes, and the filter keeps its registers and counters up to date from those reports. A register whose counters have all fallen to zero is released for reuse. A placement that needs a new register when none is free puts the filter into a safe mode. In that mode every lookup answers maybe-hit until reset, so a resident block is never reported as missing.

Top module: `tagreg_miss_filter`

## Requirements
- R1: While reset is asserted and right after it, no response is valid, and a lookup of any address reports a miss.
- R2: A lookup presented in cycle t produces `rsp_valid` high in cycle t+1 only. `rsp_valid` is low in every cycle after a cycle without a lookup.
- R3: A lookup whose upper AW-M bits match no tag register in use reports a miss (`rsp_miss`=1).
- R4: A lookup of a block address with at least one recorded placement and no later matching removal reports maybe-hit (`rsp_miss`=0).
- R5: A lookup whose upper bits match a register but whose counter, selected by that register's number and the low M bits, is zero reports a miss.
- R6: Counters track multiplicity. After two placements and one removal of an address it is still maybe-hit. After a second removal it reports a miss.
- R7: A counter that reaches its maximum (2^CW-1) never decrements again, so its address stays maybe-hit until reset.
- R8: A placement whose upper bits match no register takes the lowest free register. A register whose counters are all zero is free and can then take different upper bits.
- R9: A placement that needs a register while all K are in use switches the filter into a mode where every lookup reports maybe-hit until reset.
- R10: A lookup sees only the placements and removals of earlier cycles. A placement in the same cycle as the lookup is not yet visible.
- R11: A removal whose upper bits match no register, or whose counter is zero, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | AW | Block address to look up |
| rsp_valid | output | 1 | Lookup answer valid (one cycle after request) |
| rsp_miss | output | 1 | 1 = certain miss, 0 = maybe-hit |
| fill_valid | input | 1 | A block was placed in the cache |
| fill_addr | input | AW | Address of the placed block |
| evict_valid | input | 1 | A block was removed from the cache |
| evict_addr | input | AW | Address of the removed block |

## Verification
The checks assume that the cache reports only removals of blocks it actually placed earlier. They also assume it never reports a placement and a removal of the same address in one cycle, because a counter pair touched twice keeps its old value. The stimulus follows these rules: it removes only addresses held by the bench's own residency model, plus deliberate removals of untracked addresses, which the filter must ignore. It applies at most one placement or removal per cycle, except in the one deliberate case where a placement is paired with a lookup to probe R10. Every sweep looks up all addresses of a narrow configuration and compares each answer with a counter model computed in the bench.

// File: rtl/tagreg_miss_filter.sv
module tagreg_miss_filter #(
  parameter int AW = 32,
  parameter int M  = 4,
  parameter int K  = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  output logic          rsp_valid,
  output logic          rsp_miss,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_addr,
  input  logic          evict_valid,
  input  logic [AW-1:0] evict_addr
);
  localparam int HW = AW - M;
  localparam int IW = (K > 1) ? $clog2(K) : 1;
  localparam int PW = IW + M;
  localparam int NC = 1 << PW;
  localparam logic [CW-1:0] CMAX = '1;

  logic [HW-1:0] tag_q [K];
  logic [CW-1:0] cnt_q [NC];
  logic          ovf_q;
  logic [K-1:0]  used, lk_hit, fl_hit, ev_hit;
  logic [NC-1:0] inc_v, dec_v;

  function automatic logic [IW-1:0] first1(input logic [K-1:0] v);
    first1 = '0;
    for (int k = K - 1; k >= 0; k--)
      if (v[k]) first1 = IW'(k);
  endfunction

  always_comb begin
    for (int k = 0; k < K; k++) begin
      used[k] = 1'b0;
      for (int j = 0; j < (1 << M); j++)
        if (cnt_q[{IW'(k), M'(j)}] != '0) used[k] = 1'b1;
      lk_hit[k] = used[k] && (tag_q[k] == lk_addr[AW-1:M]);
      fl_hit[k] = used[k] && (tag_q[k] == fill_addr[AW-1:M]);
      ev_hit[k] = used[k] && (tag_q[k] == evict_addr[AW-1:M]);
    end
  end

  logic [IW-1:0] lk_idx, fl_idx, ev_idx, fr_idx;
  assign lk_idx = first1(lk_hit);
  assign fl_idx = first1(fl_hit);
  assign ev_idx = first1(ev_hit);
  assign fr_idx = first1(~used);

  logic free_any, fl_new, fill_go, ev_go, no_room;
  assign free_any = ~&used;
  assign fl_new   = fill_valid && !(|fl_hit) && free_any;
  assign no_room  = fill_valid && !(|fl_hit) && !free_any;
  assign fill_go  = fill_valid && ((|fl_hit) || free_any);
  assign ev_go    = evict_valid && (|ev_hit);

  logic [PW-1:0] fl_ptr, ev_ptr, lk_ptr;
  assign fl_ptr = {((|fl_hit) ? fl_idx : fr_idx), fill_addr[M-1:0]};
  assign ev_ptr = {ev_idx, evict_addr[M-1:0]};
  assign lk_ptr = {lk_idx, lk_addr[M-1:0]};

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      inc_v[i] = fill_go && (fl_ptr == PW'(i));
      dec_v[i] = ev_go && (ev_ptr == PW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (inc_v[i] && !dec_v[i] && cnt_q[i] != CMAX)
          cnt_q[i] <= cnt_q[i] + 1'b1;
        else if (dec_v[i] && !inc_v[i] && cnt_q[i] != '0 && cnt_q[i] != CMAX)
          cnt_q[i] <= cnt_q[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < K; k++) tag_q[k] <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (fl_new) tag_q[fr_idx] <= fill_addr[AW-1:M];
      if (no_room) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_miss  <= lk_valid && !ovf_q && (!(|lk_hit) || cnt_q[lk_ptr] == '0);
    end
  end
endmodule

module tagreg_miss_filter_chk #(
  parameter int K = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lk_valid,
  input logic         rsp_valid,
  input logic         rsp_miss,
  input logic         ovf,
  input logic [K-1:0] lk_hit
);
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r3_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !ovf && lk_hit == '0) |=> rsp_miss);
  a_r8_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(ovf)) |-> !rsp_miss);
endmodule

bind tagreg_miss_filter tagreg_miss_filter_chk #(.K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .rsp_miss(rsp_miss), .ovf(ovf_q), .lk_hit(lk_hit)
);

// File: tb/tagreg_miss_filter_tb.sv
`timescale 1ns/1ps
module tagreg_miss_filter_tb;
  localparam int AW = 8, M = 2, K = 2, CW = 2;
  localparam int NA = 1 << AW;
  localparam int CMX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fill_valid = 0, evict_valid = 0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0, evict_addr = '0;
  logic rsp_valid, rsp_miss;

  tagreg_miss_filter #(.AW(AW), .M(M), .K(K), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int c [NA];
  bit ovf_m;
  bit done = 0;

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic bit live(input int g);
    live = 0;
    for (int j = 0; j < (1 << M); j++) if (c[(g << M) + j] != 0) live = 1;
  endfunction

  function automatic int nlive();
    nlive = 0;
    for (int g = 0; g < (NA >> M); g++) if (live(g)) nlive++;
  endfunction

  function automatic int exp_miss(input int a);
    exp_miss = ovf_m ? 0 : (c[a] == 0 ? 1 : 0);
  endfunction

  function automatic string auto_tag(input int a);
    if (ovf_m) auto_tag = "R9";
    else if (c[a] != 0) auto_tag = "R4";
    else if (!live(a >> M)) auto_tag = "R3";
    else auto_tag = "R5";
  endfunction

  task automatic model_fill(input int a);
    if (live(a >> M)) begin
      if (c[a] < CMX) c[a]++;
    end else if (nlive() < K) c[a] = 1;
    else ovf_m = 1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    @(negedge clk); rst_n = 1;
    for (int a = 0; a < NA; a++) c[a] = 0;
    ovf_m = 0;
  endtask

  task automatic fill(input int a);
    @(negedge clk); fill_valid = 1; fill_addr = AW'(a);
    @(negedge clk); fill_valid = 0;
    model_fill(a);
  endtask

  task automatic evict(input int a);
    @(negedge clk); evict_valid = 1; evict_addr = AW'(a);
    @(negedge clk); evict_valid = 0;
    if (live(a >> M) && c[a] != 0 && c[a] != CMX) c[a]--;
  endtask

  task automatic look(input int a, input string tag);
    int e;
    string t;
    e = exp_miss(a);
    t = (tag == "") ? auto_tag(a) : tag;
    @(negedge clk); lk_valid = 1; lk_addr = AW'(a);
    @(negedge clk); lk_valid = 0;
    chk("R2 rsp_valid", rsp_valid, 1);
    chk(t, rsp_miss, e);
  endtask

  task automatic sweep();
    for (int a = 0; a < NA; a++) look(a, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R2 idle rsp_valid", rsp_valid, 0);
    look(8'h14, "R1");
    sweep();

    fill(8'h14); sweep();
    fill(8'h17); fill(8'h14); sweep();
    evict(8'h14); look(8'h14, "R6"); sweep();
    evict(8'h14); look(8'h14, "R6"); sweep();

    fill(8'h17); fill(8'h17); fill(8'h17);
    for (int i = 0; i < 4; i++) evict(8'h17);
    look(8'h17, "R7"); sweep();

    fill(8'h40); look(8'h40, "R8"); sweep();
    evict(8'h40); look(8'h41, "R8");
    fill(8'h80); look(8'h80, "R8"); look(8'h40, "R8"); sweep();

    evict(8'hC1); evict(8'h15);
    look(8'hC1, "R11"); look(8'h15, "R11"); look(8'h17, "R11"); sweep();

    // R10: a fill in the lookup cycle is not yet visible
    @(negedge clk);
    fill_valid = 1; fill_addr = 8'h81; lk_valid = 1; lk_addr = 8'h81;
    @(negedge clk); fill_valid = 0; lk_valid = 0;
    chk("R10 same-cycle fill", rsp_miss, 1);
    model_fill(8'h81);
    look(8'h81, "R10");

    fill(8'hC0); look(8'hC0, "R9"); look(8'h00, "R9"); sweep();
    evict(8'h80); evict(8'h81); sweep();

    do_reset();
    look(8'h17, "R1"); sweep();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule